// File: doc/BRIEF.md
# Reset-Time Default Register Loader

This block brings three serially programmed devices to a known state each time the board comes out of reset. The three devices are one timing generator and two analog front ends. When power-on reset, the reset push button or the remote reset line is released, the block walks a small constant table of register defaults. It sends each entry as one serial frame on a shared clock and data pair, with a separate load strobe for each device. After the last frame it raises a done flag. From then on it hands the serial pins to the host.

Two mode switches pick some of the defaults. The binning switch selects the frame-table pointer value. The channel switch selects between the one-channel and two-channel values of the timing generator's output-enable register and its pixel-rate signal offset register. Both switches are synchronised and captured while reset is held. They are frozen when reset is released and are ignored until the next reset.

The serial side has no handshake and no back-pressure. The devices must accept each frame at the rate the block sends it, so every pin is plain control.

Top module: `reset_default_loader`

## Requirements
- R1: After power-on reset is released, and again after every button or remote reset is released, the block sends exactly 10 frames and then drives `load_done` high. `load_done` is low from any reset until the last frame of the following load has finished.
- R2: While `por_n` is low, or `btn_rst` or `remote_rst` is high, the block stays idle: `load_done`, `ser_clk` and every bit of `ser_load` are low. The load starts only after every reset source is released.
- R3: In a frame, exactly one `ser_load` bit is high and stays high for the whole frame. Bit 0 selects the timing generator, bit 1 the first front end and bit 2 the second front end. The frame carries 16 bits, each valid on a rising edge of `ser_clk`: first a 4-bit register address, least significant bit first, then 12 data bits, least significant bit first.
- R4: The frame order is fixed. First the timing-generator registers 0, 1, 4 and 6. Then the first front end's registers 0, 2 and 3. Then the same three registers of the second front end. All `ser_load` bits are low for at least 2 clock cycles between frames.
- R5: Timing-generator register 0, the frame-table pointer, is loaded with 2 when the binning switch was high at reset, and with 0 otherwise.
- R6: With the channel switch high at reset, timing-generator register 1 is loaded with 0xFFF and register 6 with 0x024. With the switch low they are loaded with 0x5F3 and 0x012.
- R7: Values that do not depend on the switches: timing-generator register 4 (shutter line) = 2040, which means no shutter pulse. Each front end gets register 0 = 0x0A0 and register 3 (gain) = 0x0E6.
- R8: Register 2 of each front end is loaded with 96, the code its output clamps to during the black-level clamp period.
- R9: Until `load_done` is high, `host_sclk`, `host_sdata` and `host_sload` have no effect on the serial outputs. Once it is high, `ser_clk`, `ser_data` and `ser_load` follow them.
- R10: Switch values are taken from the reset period. Changing the switches after reset has been released does not change any value loaded by that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| btn_rst | input | 1 | Reset push button, active high, asynchronous |
| remote_rst | input | 1 | Remote reset level, active high, asynchronous |
| sw_binning | input | 1 | Binning-mode switch, asynchronous |
| sw_two_chan | input | 1 | Two-channel switch, asynchronous |
| host_sclk | input | 1 | Host serial clock, passed through after the load |
| host_sdata | input | 1 | Host serial data, passed through after the load |
| host_sload | input | 3 | Host device load strobes, passed through after the load |
| ser_clk | output | 1 | Serial clock to the devices |
| ser_data | output | 1 | Serial data to the devices |
| ser_load | output | 3 | Per-device load strobes (bit 0 timing generator, bits 1 and 2 front ends) |
| load_done | output | 1 | Default load complete |

## Verification
The bench runs every switch combination through button and remote resets. It decodes each frame back into strobe, address and data. A table built from the wrong switch, or with an address and data order swapped, shows up there as a wrong value or a misplaced register. The host lines are driven fully active during every load. A loader that let them through would produce a strobe pattern with more than one bit set, or broken frames. In one case the switches are flipped just after reset is released, which catches a design that samples them continuously. Another case holds the remote reset high for a long time and checks that nothing moves until it is released.

// File: rtl/ld_pkg.sv
package ld_pkg;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 12;
  localparam int FRAME_W     = ADDR_W + DATA_W;
  localparam int NUM_DEV     = 3;
  localparam int NUM_ENTRIES = 10;
  localparam int TG_ENTRIES  = 4;
  localparam int AFE_REGS    = 3;

  typedef enum logic [1:0] {
    DEV_TG   = 2'd0,
    DEV_AFE1 = 2'd1,
    DEV_AFE2 = 2'd2
  } dev_e;

  typedef struct packed {
    logic binning;
    logic two_chan;
  } cfg_t;

  // timing generator register addresses, in send order
  localparam logic [ADDR_W-1:0] TG_A_FTPTR = 4'd0;
  localparam logic [ADDR_W-1:0] TG_A_OE    = 4'd1;
  localparam logic [ADDR_W-1:0] TG_A_SHUT  = 4'd4;
  localparam logic [ADDR_W-1:0] TG_A_POFS  = 4'd6;
  // front end register addresses, in send order
  localparam logic [ADDR_W-1:0] AFE_A_OP    = 4'd0;
  localparam logic [ADDR_W-1:0] AFE_A_CLAMP = 4'd2;
  localparam logic [ADDR_W-1:0] AFE_A_GAIN  = 4'd3;

  localparam logic [DATA_W-1:0] V_FTPTR_BIN  = 12'd2;
  localparam logic [DATA_W-1:0] V_FTPTR_NORM = 12'd0;
  localparam logic [DATA_W-1:0] V_OE_1CH     = 12'h5F3;
  localparam logic [DATA_W-1:0] V_OE_2CH     = 12'hFFF;
  localparam logic [DATA_W-1:0] V_POFS_1CH   = 12'h012;
  localparam logic [DATA_W-1:0] V_POFS_2CH   = 12'h024;
  localparam logic [DATA_W-1:0] V_SHUT_NONE  = 12'd2040;
  localparam logic [DATA_W-1:0] V_AFE_OP     = 12'h0A0;
  localparam logic [DATA_W-1:0] V_AFE_CLAMP  = 12'd96;
  localparam logic [DATA_W-1:0] V_AFE_GAIN   = 12'h0E6;
endpackage

// File: rtl/ld_reset_ctrl.sv
module ld_reset_ctrl
  import ld_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POR_HOLD    = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic btn_rst,
  input  logic remote_rst,
  input  logic sw_binning,
  input  logic sw_two_chan,
  output logic rst_req,
  output cfg_t cfg
);
  localparam int NSYNC = 4;
  localparam int PCW   = $clog2(POR_HOLD + 1);

  logic [NSYNC-1:0] raw;
  logic [NSYNC-1:0] stg [SYNC_STAGES];
  logic [NSYNC-1:0] synced;
  logic [PCW-1:0]   por_cnt;
  logic             por_busy;

  assign raw = {sw_two_chan, sw_binning, remote_rst, btn_rst};

  // synchroniser chain, one register stage per generate step
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stg[0] <= '0;
        else        stg[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end
  assign synced = stg[SYNC_STAGES-1];

  // stretch power-on reset until the synchronisers carry real switch values
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                        por_cnt <= '0;
    else if (por_cnt != PCW'(POR_HOLD)) por_cnt <= por_cnt + 1'b1;
  end
  assign por_busy = (por_cnt != PCW'(POR_HOLD));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rst_req <= 1'b1;
    else        rst_req <= por_busy | synced[0] | synced[1];
  end

  // switches follow the synchroniser only while reset is held
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg <= '0;
    end else if (rst_req) begin
      cfg.binning  <= synced[2];
      cfg.two_chan <= synced[3];
    end
  end

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_req && !$past(rst_req)) |-> $stable(cfg));
endmodule

// File: rtl/ld_default_rom.sv
module ld_default_rom
  import ld_pkg::*;
#(
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [IDX_W-1:0]  idx,
  input  cfg_t              cfg,
  output dev_e              dev,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam int AFE2_BASE = TG_ENTRIES + AFE_REGS;

  logic [IDX_W-1:0] afe_k;

  always_comb begin
    afe_k = '0;
    if (idx >= IDX_W'(AFE2_BASE))       afe_k = idx - IDX_W'(AFE2_BASE);
    else if (idx >= IDX_W'(TG_ENTRIES)) afe_k = idx - IDX_W'(TG_ENTRIES);
  end

  always_comb begin
    dev  = DEV_TG;
    addr = '0;
    data = '0;
    if (idx < IDX_W'(TG_ENTRIES)) begin
      dev = DEV_TG;
      case (idx[1:0])
        2'd0: begin
          addr = TG_A_FTPTR;
          data = cfg.binning ? V_FTPTR_BIN : V_FTPTR_NORM;
        end
        2'd1: begin
          addr = TG_A_OE;
          data = cfg.two_chan ? V_OE_2CH : V_OE_1CH;
        end
        2'd2: begin
          addr = TG_A_SHUT;
          data = V_SHUT_NONE;
        end
        default: begin
          addr = TG_A_POFS;
          data = cfg.two_chan ? V_POFS_2CH : V_POFS_1CH;
        end
      endcase
    end else begin
      dev = (idx < IDX_W'(AFE2_BASE)) ? DEV_AFE1 : DEV_AFE2;
      case (afe_k)
        IDX_W'(0): begin addr = AFE_A_OP;    data = V_AFE_OP;    end
        IDX_W'(1): begin addr = AFE_A_CLAMP; data = V_AFE_CLAMP; end
        default:   begin addr = AFE_A_GAIN;  data = V_AFE_GAIN;  end
      endcase
    end
  end
endmodule

// File: rtl/ld_serializer.sv
module ld_serializer
  import ld_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               clr,
  input  logic               start,
  input  dev_e               dev,
  input  logic [FRAME_W-1:0] word,
  output logic               fin,
  output logic               sclk,
  output logic               sdata,
  output logic [NUM_DEV-1:0] sload
);
  localparam int CW = $clog2(FRAME_W);
  localparam int GW = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {SR_IDLE, SR_SHIFT, SR_GAP} sr_e;

  sr_e                st;
  logic               ph;
  logic [CW-1:0]      cnt;
  logic [GW-1:0]      gcnt;
  logic [FRAME_W-1:0] shreg;
  logic [NUM_DEV-1:0] sel;
  logic [NUM_DEV-1:0] dev_hot;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_hot
    assign dev_hot[g] = (32'(dev) == g);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st <= SR_IDLE; ph <= 1'b0; cnt <= '0; gcnt <= '0; shreg <= '0; sel <= '0;
    end else if (clr) begin
      st <= SR_IDLE; ph <= 1'b0; cnt <= '0; gcnt <= '0; sel <= '0;
    end else begin
      case (st)
        SR_IDLE: if (start) begin
          shreg <= word;
          sel   <= dev_hot;
          cnt   <= '0;
          ph    <= 1'b0;
          st    <= SR_SHIFT;
        end
        SR_SHIFT: begin
          if (!ph) begin
            ph <= 1'b1;
          end else begin
            ph <= 1'b0;
            if (cnt == CW'(FRAME_W - 1)) begin
              st   <= SR_GAP;
              gcnt <= '0;
            end else begin
              cnt   <= cnt + 1'b1;
              shreg <= shreg >> 1;
            end
          end
        end
        SR_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gcnt == GW'(GAP_CYC - 1)) st <= SR_IDLE;
        end
        default: st <= SR_IDLE;
      endcase
    end
  end

  assign fin   = (st == SR_GAP) && (gcnt == GW'(GAP_CYC - 1));
  assign sclk  = (st == SR_SHIFT) && ph;
  assign sdata = shreg[0];
  assign sload = (st == SR_SHIFT) ? sel : '0;

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(sload));
  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!por_n || clr)
    (st == SR_SHIFT && $past(st) == SR_SHIFT) |-> $stable(sload));
  // R4
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == SR_IDLE && $past(st) == SR_GAP) |-> ($past(sload) == '0 && sload == '0));
endmodule

// File: rtl/reset_default_loader.sv
module reset_default_loader
  import ld_pkg::*;
#(
  parameter int GAP_CYC     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int POR_HOLD    = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       btn_rst,
  input  logic       remote_rst,
  input  logic       sw_binning,
  input  logic       sw_two_chan,
  input  logic       host_sclk,
  input  logic       host_sdata,
  input  logic [2:0] host_sload,
  output logic       ser_clk,
  output logic       ser_data,
  output logic [2:0] ser_load,
  output logic       load_done
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  typedef enum logic [1:0] {SQ_HOLD, SQ_ISSUE, SQ_WAIT, SQ_DONE} sq_e;

  logic               rst_req;
  cfg_t               cfg;
  sq_e                st;
  logic [IDX_W-1:0]   idx;
  dev_e               r_dev;
  logic [ADDR_W-1:0]  r_addr;
  logic [DATA_W-1:0]  r_data;
  logic               fin;
  logic               ld_sclk, ld_sdata;
  logic [NUM_DEV-1:0] ld_sload;

  ld_reset_ctrl #(.SYNC_STAGES(SYNC_STAGES), .POR_HOLD(POR_HOLD)) u_rst (
    .clk(clk), .por_n(por_n), .btn_rst(btn_rst), .remote_rst(remote_rst),
    .sw_binning(sw_binning), .sw_two_chan(sw_two_chan),
    .rst_req(rst_req), .cfg(cfg)
  );

  ld_default_rom #(.IDX_W(IDX_W)) u_rom (
    .idx(idx), .cfg(cfg), .dev(r_dev), .addr(r_addr), .data(r_data)
  );

  ld_serializer #(.GAP_CYC(GAP_CYC)) u_ser (
    .clk(clk), .por_n(por_n), .clr(rst_req), .start(st == SQ_ISSUE),
    .dev(r_dev), .word({r_data, r_addr}), .fin(fin),
    .sclk(ld_sclk), .sdata(ld_sdata), .sload(ld_sload)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st <= SQ_HOLD; idx <= '0; load_done <= 1'b0;
    end else if (rst_req) begin
      st <= SQ_HOLD; idx <= '0; load_done <= 1'b0;
    end else begin
      case (st)
        SQ_HOLD:  begin st <= SQ_ISSUE; idx <= '0; end
        SQ_ISSUE: st <= SQ_WAIT;
        SQ_WAIT: if (fin) begin
          if (idx == IDX_W'(NUM_ENTRIES - 1)) begin
            st        <= SQ_DONE;
            load_done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            st  <= SQ_ISSUE;
          end
        end
        default: st <= SQ_DONE;
      endcase
    end
  end

  // host owns the pins only after the defaults are in
  assign ser_clk  = load_done ? host_sclk  : ld_sclk;
  assign ser_data = load_done ? host_sdata : ld_sdata;
  assign ser_load = load_done ? host_sload : ld_sload;

  // R2
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == SQ_HOLD) |-> (ser_load == '0 && !ser_clk && !load_done));
  // R1
  done_fall_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(load_done) |-> $past(rst_req));
  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    (idx != $past(idx)) |-> (idx == $past(idx) + 1'b1 || idx == '0));
  // R9
  strobe_owner_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ld_sload != '0) |-> (st == SQ_WAIT && !load_done));
endmodule

// File: tb/reset_default_loader_tb.sv
module reset_default_loader_tb;
  logic       clk = 1'b0;
  logic       por_n, btn_rst, remote_rst, sw_binning, sw_two_chan;
  logic       host_sclk, host_sdata;
  logic [2:0] host_sload;
  logic       ser_clk, ser_data, load_done;
  logic [2:0] ser_load;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  reset_default_loader u_dut (
    .clk(clk), .por_n(por_n), .btn_rst(btn_rst), .remote_rst(remote_rst),
    .sw_binning(sw_binning), .sw_two_chan(sw_two_chan),
    .host_sclk(host_sclk), .host_sdata(host_sdata), .host_sload(host_sload),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .load_done(load_done)
  );

  // {binning, two_chan, use_remote, flip_after_release}
  localparam logic [3:0] VEC [5] = '{4'b1000, 4'b0110, 4'b1100, 4'b0001, 4'b1111};

  // frame capture
  logic        cap_en = 1'b0;
  int          cap_n, gap_min, gapc, bitc, bad_strobe;
  logic [2:0]  cap_dev [16];
  logic [15:0] cap_word [16];
  int          cap_bits [16];
  logic [15:0] sh;
  logic        prev_sclk = 1'b0;
  logic [2:0]  prev_load = 3'b000;

  always @(negedge clk) begin
    if (cap_en && !load_done) begin
      if (ser_load != 3'b000) begin
        if (prev_load == 3'b000) begin
          bitc = 0;
          if (cap_n > 0 && gapc < gap_min) gap_min = gapc;
        end else if (ser_load != prev_load) begin
          bad_strobe++;
        end
        if ($countones(ser_load) != 1) bad_strobe++;
        if (ser_clk && !prev_sclk) begin
          sh = {ser_data, sh[15:1]};
          bitc++;
        end
      end else if (prev_load != 3'b000) begin
        if (cap_n < 16) begin
          cap_dev[cap_n]  = prev_load;
          cap_word[cap_n] = sh;
          cap_bits[cap_n] = bitc;
        end
        cap_n++;
        gapc = 1;
      end else begin
        gapc++;
      end
      prev_sclk = ser_clk;
      prev_load = ser_load;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_cap();
    cap_n = 0; gap_min = 1000; gapc = 0; bitc = 0; bad_strobe = 0; sh = '0;
    prev_sclk = 1'b0; prev_load = 3'b000;
    cap_en = 1'b1;
  endtask

  task automatic host_busy(input bit on);
    host_sclk  = on;
    host_sdata = on;
    host_sload = on ? 3'b111 : 3'b000;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!load_done && t < 5000) begin cyc(1); t++; end
    chk(load_done, req, int'(load_done), 1);
    cap_en = 1'b0;
  endtask

  // expected frame per requirements: strobe one-hot and {data, addr}
  task automatic exp_frame(input int i, input bit b, input bit t,
                           output logic [2:0] dev, output logic [15:0] w, output string req);
    logic [3:0]  a;
    logic [11:0] d;
    if (i < 4) begin
      dev = 3'b001;
      case (i)
        0: begin a = 4'd0; d = b ? 12'd2 : 12'd0;         req = "R5"; end
        1: begin a = 4'd1; d = t ? 12'hFFF : 12'h5F3;     req = "R6"; end
        2: begin a = 4'd4; d = 12'd2040;                  req = "R7"; end
        default: begin a = 4'd6; d = t ? 12'h024 : 12'h012; req = "R6"; end
      endcase
    end else begin
      dev = (i < 7) ? 3'b010 : 3'b100;
      case ((i - 4) % 3)
        0: begin a = 4'd0; d = 12'h0A0; req = "R7"; end
        1: begin a = 4'd2; d = 12'd96;  req = "R8"; end
        default: begin a = 4'd3; d = 12'h0E6; req = "R7"; end
      endcase
    end
    w = {d, a};
  endtask

  task automatic verify(input bit b, input bit t, input bit flipped);
    logic [2:0]  ed;
    logic [15:0] ew;
    string       rq;
    chk(cap_n == 10, "R1 frame count", cap_n, 10);
    chk(gap_min >= 2, "R4 inter-frame gap", gap_min, 2);
    chk(bad_strobe == 0, "R3/R9 strobe shape", bad_strobe, 0);
    for (int i = 0; i < 10 && i < cap_n; i++) begin
      exp_frame(i, b, t, ed, ew, rq);
      chk(cap_dev[i] == ed, "R4 device order", int'(cap_dev[i]), int'(ed));
      chk(cap_bits[i] == 16, "R3 frame length", cap_bits[i], 16);
      if (flipped) chk(cap_word[i] == ew, "R10 latched value", int'(cap_word[i]), int'(ew));
      else         chk(cap_word[i] == ew, rq, int'(cap_word[i]), int'(ew));
    end
  endtask

  initial begin
    #1000000;
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    por_n = 1'b0; btn_rst = 1'b0; remote_rst = 1'b0;
    sw_binning = 1'b0; sw_two_chan = 1'b0;
    host_busy(1'b0);
    cyc(4);
    // R2 reset state under power-on reset
    chk(load_done == 1'b0, "R2 reset done", int'(load_done), 0);
    chk(ser_load == 3'b000, "R2 reset strobes", int'(ser_load), 0);
    chk(ser_clk == 1'b0, "R2 reset sclk", int'(ser_clk), 0);

    // R1 power-up load, host lines busy throughout (R9)
    host_busy(1'b1);
    clear_cap();
    por_n = 1'b1;
    wait_done("R1 power-up done");
    verify(1'b0, 1'b0, 1'b0);

    // vector walk: switch combinations, reset source, late switch flips
    foreach (VEC[k]) begin
      logic b, t;
      b = VEC[k][3]; t = VEC[k][2];
      sw_binning = b; sw_two_chan = t;
      cyc(4);
      clear_cap();
      if (VEC[k][1]) remote_rst = 1'b1; else btn_rst = 1'b1;
      cyc(6);
      chk(load_done == 1'b0, "R1 done cleared by reset", int'(load_done), 0);
      remote_rst = 1'b0; btn_rst = 1'b0;
      if (VEC[k][0]) begin
        cyc(10);
        sw_binning = ~b; sw_two_chan = ~t;   // R10 changes after release
      end
      wait_done("R1 reload done");
      verify(b, t, VEC[k][0]);
    end

    // R9 passthrough after done
    host_sclk = 1'b1; host_sdata = 1'b0; host_sload = 3'b101;
    cyc(1);
    chk(ser_load == 3'b101, "R9 host strobe pass", int'(ser_load), 5);
    chk(ser_clk == 1'b1 && ser_data == 1'b0, "R9 host clk/data pass",
        int'({ser_clk, ser_data}), 2);

    // R2 long remote reset keeps loader idle, host blocked (R9)
    host_busy(1'b1);
    sw_binning = 1'b1; sw_two_chan = 1'b0;
    remote_rst = 1'b1;
    cyc(40);
    chk(load_done == 1'b0, "R2 held remote done", int'(load_done), 0);
    chk(ser_load == 3'b000, "R2/R9 held remote strobes", int'(ser_load), 0);
    chk(ser_clk == 1'b0, "R2/R9 held remote sclk", int'(ser_clk), 0);
    clear_cap();
    remote_rst = 1'b0;
    wait_done("R2 load after remote release");
    verify(1'b1, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule